// File: doc/BRIEF.md
# Display Data Channel Slave Mode Controller

This block is the slave side of a monitor's display data channel. After reset it runs in the one-way mode: the byte in a transmit buffer is sent serially, most significant bit first, one bit on each rising edge of the vertical sync input. Each byte is followed by a ninth slot in which the line is held high. When a new byte is taken from the buffer, a one-cycle request asks software to refill the buffer.

The first falling edge seen on the serial clock line switches the block into the two-way mode. Here a byte-level serial bus slave answers two addresses, and each address has its own receive and transmit register. Slave A can compare 7, 6 or 5 address bits, so it can answer a small group of addresses. In that case it records the bits it treated as don't-care. Slave B always compares all 7 bits. If the clock line stays high through a configured number of vertical sync periods, the block falls back to the one-way mode. The bit-level bus timing and the data storage sit outside this block. It exchanges whole address and data bytes with them as strobes.

Top module: `ddc_slave_ctrl`

## Requirements
- R1: After reset the block is in the one-way mode (`ddc2_mode`=0), `ddc1_sda` is 1, and `ddc1_req`, `adr_ack`, `sel_a`, `sel_b`, `rx_a_stb`, `rx_b_stb` and `rd_stb` are 0.
- R2: In the one-way mode, each rising edge of `vsync_in` advances one slot of a 9-slot frame. The first 8 slots drive the latched byte's bits 7 down to 0 on `ddc1_sda`, and the ninth slot drives 1. The output changes in the cycle after the clock edge that sees the rise.
- R3: At the rise that starts a frame, the byte in `ddc1_byte` is latched and `ddc1_req` is 1 for exactly one cycle. No request occurs at any other time.
- R4: In the one-way mode, a high-to-low change of `scl_in` sets `ddc2_mode` in the next cycle. While `ddc2_mode`=1, `ddc1_sda` is 1 and `vsync_in` rises raise no request.
- R5: In the two-way mode, `ddc2_mode` clears after IDLE_VSYNC rises of `vsync_in` (default 128) with `scl_in` high throughout. Any cycle with `scl_in` low restarts this count.
- R6: The `a_width` code of slave A sets how many upper address bits it compares: 0 or 3 compares all 7, 1 compares bits 6..1, 2 compares bits 6..2.
- R7: When slave A matches, `a_wild` loads the address bits it treated as don't-care (bit 0 in 6-bit mode, bits 1..0 in 5-bit mode) and zeros in compared positions. Otherwise `a_wild` keeps its value.
- R8: An address byte (`adr_byte[7:1]` is the address, `adr_byte[0]`=1 means read) gives a one-cycle `adr_ack` if either slave matches. Slave B compares all 7 bits. If both match, slave A wins. Exactly the winner's select is set, and a byte that matches neither slave clears both selects.
- R9: In a write transfer, `wr_valid` copies `wr_data` into the selected slave's receive register, with its strobe high for one cycle. Nothing changes when no slave is selected or the transfer is a read.
- R10: In a read transfer, `rd_req` returns the selected slave's transmit byte on `rd_data` with `rd_stb` high for one cycle. A `stop` pulse clears both selects.
- R11: Address bytes offered in the one-way mode are ignored: no ack and no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Synchronised serial clock line level |
| vsync_in | input | 1 | Synchronised vertical sync level |
| ddc1_byte | input | 8 | One-way mode transmit buffer |
| ddc1_sda | output | 1 | One-way mode serial data out |
| ddc1_req | output | 1 | Buffer refill request pulse |
| ddc2_mode | output | 1 | 1 while in the two-way mode |
| a_addr | input | 7 | Slave A address |
| a_width | input | 2 | Slave A compare-width code |
| b_addr | input | 7 | Slave B address |
| adr_valid | input | 1 | Address byte strobe from the bit engine |
| adr_byte | input | 8 | Address plus read flag |
| adr_ack | output | 1 | Address acknowledged pulse |
| sel_a | output | 1 | Slave A selected |
| sel_b | output | 1 | Slave B selected |
| a_wild | output | 2 | Captured don't-care address bits of slave A |
| wr_valid | input | 1 | Received data byte strobe |
| wr_data | input | 8 | Received data byte |
| rx_a_data | output | 8 | Slave A receive register |
| rx_a_stb | output | 1 | Slave A receive pulse |
| rx_b_data | output | 8 | Slave B receive register |
| rx_b_stb | output | 1 | Slave B receive pulse |
| rd_req | input | 1 | Master wants the next read byte |
| tx_a_data | input | 8 | Slave A transmit byte |
| tx_b_data | input | 8 | Slave B transmit byte |
| rd_data | output | 8 | Byte handed to the bit engine |
| rd_stb | output | 1 | Read byte valid pulse |
| stop | input | 1 | Bus stop condition pulse |

## Verification
The bench targets the idle count. With the clock line high it gives 127 sync rises and then the 128th, and it repeats this after a brief low on the line. A design that counts one rise off, or never clears the count, drops back a period early or late. It walks a full frame to catch a byte shifted out least significant bit first or a missing ninth high slot. It offers random addresses near slave A's address under every width code, with both slaves set to overlapping addresses. A wrong mask, a wrong winner or stale don't-care bits show up there as a wrong ack, a wrong select or wrong `a_wild`. It also sends address bytes in the one-way mode and data bytes with no slave selected, which a careless design would accept.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
    localparam int DDC_ADDR_W = 7;
    localparam int DDC_WILD_W = 2;

    typedef enum logic [1:0] {
        AW_FULL  = 2'd0,
        AW_SIX   = 2'd1,
        AW_FIVE  = 2'd2,
        AW_SPARE = 2'd3
    } aw_code_e;
endpackage

// File: rtl/ddc_mode_fsm.sv
module ddc_mode_fsm #(
    parameter int IDLE_VSYNC = 128,
    localparam int CNT_W = $clog2(IDLE_VSYNC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic vs_rise,
    output logic ddc2_o
);
    typedef struct packed {
        logic             ddc2;
        logic             scl_prev;
        logic [CNT_W-1:0] idle_cnt;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.scl_prev = scl_in;
        if (!st_q.ddc2) begin
            st_d.idle_cnt = '0;
            if (st_q.scl_prev && !scl_in) begin
                st_d.ddc2 = 1'b1;
            end
        end else if (!scl_in) begin
            st_d.idle_cnt = '0;
        end else if (vs_rise) begin
            if (st_q.idle_cnt == CNT_W'(IDLE_VSYNC - 1)) begin
                st_d.ddc2     = 1'b0;
                st_d.idle_cnt = '0;
            end else begin
                st_d.idle_cnt = st_q.idle_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ddc2     <= 1'b0;
            st_q.scl_prev <= 1'b1;
            st_q.idle_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ddc2_o = st_q.ddc2;
endmodule

// File: rtl/ddc1_shifter.sv
module ddc1_shifter #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              vs_rise,
    input  logic [DATA_W-1:0] buf_byte,
    output logic              sda_o,
    output logic              req_o
);
    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic [IDX_W-1:0]  slot;
        logic              req;
    } shf_st_t;

    shf_st_t st_d, st_q;
    logic    in_tail;

    assign in_tail = (st_q.slot == IDX_W'(DATA_W));

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (!run) begin
            st_d.slot = IDX_W'(DATA_W);
        end else if (vs_rise) begin
            if (in_tail) begin
                st_d.shreg = buf_byte;
                st_d.slot  = '0;
                st_d.req   = 1'b1;
            end else begin
                st_d.shreg = {st_q.shreg[DATA_W-2:0], 1'b0};
                st_d.slot  = st_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shreg <= '0;
            st_q.slot  <= IDX_W'(DATA_W);
            st_q.req   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_o = in_tail | st_q.shreg[DATA_W-1];
    assign req_o = st_q.req;
endmodule

// File: rtl/ddc_addr_cmp.sv
module ddc_addr_cmp
    import ddc_pkg::*;
#(
    parameter bit PROG_WIDTH = 1'b1
) (
    input  logic [DDC_ADDR_W-1:0] own_addr,
    input  logic [1:0]            width_code,
    input  logic [DDC_ADDR_W-1:0] rx_addr,
    output logic                  hit,
    output logic [DDC_WILD_W-1:0] wild
);
    logic [DDC_ADDR_W-1:0] care;

    generate
        if (PROG_WIDTH) begin : g_prog
            always_comb begin
                care = '1;
                case (aw_code_e'(width_code))
                    AW_SIX:  care[0]   = 1'b0;
                    AW_FIVE: care[1:0] = 2'b00;
                    default: care      = '1;
                endcase
            end
        end else begin : g_fixed
            logic unused_code;
            assign unused_code = ^width_code;
            assign care        = '1;
        end
    endgenerate

    assign hit  = ((own_addr ^ rx_addr) & care) == '0;
    assign wild = rx_addr[DDC_WILD_W-1:0] & ~care[DDC_WILD_W-1:0];
endmodule

// File: rtl/ddc2_slave.sv
module ddc2_slave
    import ddc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active,
    input  logic [DDC_ADDR_W-1:0] a_addr,
    input  logic [1:0]            a_width,
    input  logic [DDC_ADDR_W-1:0] b_addr,
    input  logic                  adr_valid,
    input  logic [DDC_ADDR_W:0]   adr_byte,
    input  logic                  wr_valid,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_req,
    input  logic                  stop,
    input  logic [DATA_W-1:0]     tx_a_data,
    input  logic [DATA_W-1:0]     tx_b_data,
    output logic                  adr_ack,
    output logic                  sel_a,
    output logic                  sel_b,
    output logic [DDC_WILD_W-1:0] a_wild,
    output logic [DATA_W-1:0]     rx_a_data,
    output logic                  rx_a_stb,
    output logic [DATA_W-1:0]     rx_b_data,
    output logic                  rx_b_stb,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_stb
);
    localparam int NSLV = 2;

    typedef struct packed {
        logic                  sel_a;
        logic                  sel_b;
        logic                  is_read;
        logic                  ack;
        logic [DDC_WILD_W-1:0] wild;
        logic [DATA_W-1:0]     rx_a;
        logic                  rx_a_stb;
        logic [DATA_W-1:0]     rx_b;
        logic                  rx_b_stb;
        logic [DATA_W-1:0]     rd;
        logic                  rd_stb;
    } slv_st_t;

    slv_st_t st_d, st_q;

    logic [NSLV-1:0]                 hit;
    logic [NSLV-1:0][DDC_WILD_W-1:0] wild;
    logic [NSLV-1:0][DDC_ADDR_W-1:0] own;

    assign own[0] = a_addr;
    assign own[1] = b_addr;

    generate
        for (genvar s = 0; s < NSLV; s++) begin : g_cmp
            ddc_addr_cmp #(.PROG_WIDTH(s == 0)) i_cmp (
                .own_addr  (own[s]),
                .width_code(a_width),
                .rx_addr   (adr_byte[DDC_ADDR_W:1]),
                .hit       (hit[s]),
                .wild      (wild[s])
            );
        end
    endgenerate

    logic unused_wild_b;
    assign unused_wild_b = ^wild[1];

    always_comb begin
        st_d          = st_q;
        st_d.ack      = 1'b0;
        st_d.rx_a_stb = 1'b0;
        st_d.rx_b_stb = 1'b0;
        st_d.rd_stb   = 1'b0;
        if (!active) begin
            st_d.sel_a = 1'b0;
            st_d.sel_b = 1'b0;
        end else if (adr_valid) begin
            st_d.sel_a   = hit[0];
            st_d.sel_b   = !hit[0] && hit[1];
            st_d.is_read = adr_byte[0];
            st_d.ack     = |hit;
            if (hit[0]) begin
                st_d.wild = wild[0];
            end
        end else if (stop) begin
            st_d.sel_a = 1'b0;
            st_d.sel_b = 1'b0;
        end else begin
            if (wr_valid && !st_q.is_read) begin
                if (st_q.sel_a) begin
                    st_d.rx_a     = wr_data;
                    st_d.rx_a_stb = 1'b1;
                end
                if (st_q.sel_b) begin
                    st_d.rx_b     = wr_data;
                    st_d.rx_b_stb = 1'b1;
                end
            end
            if (rd_req && st_q.is_read) begin
                if (st_q.sel_a) begin
                    st_d.rd     = tx_a_data;
                    st_d.rd_stb = 1'b1;
                end else if (st_q.sel_b) begin
                    st_d.rd     = tx_b_data;
                    st_d.rd_stb = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign adr_ack   = st_q.ack;
    assign sel_a     = st_q.sel_a;
    assign sel_b     = st_q.sel_b;
    assign a_wild    = st_q.wild;
    assign rx_a_data = st_q.rx_a;
    assign rx_a_stb  = st_q.rx_a_stb;
    assign rx_b_data = st_q.rx_b;
    assign rx_b_stb  = st_q.rx_b_stb;
    assign rd_data   = st_q.rd;
    assign rd_stb    = st_q.rd_stb;
endmodule

// File: rtl/ddc_slave_ctrl.sv
module ddc_slave_ctrl #(
    parameter int DATA_W     = 8,
    parameter int IDLE_VSYNC = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              vsync_in,
    input  logic [DATA_W-1:0] ddc1_byte,
    output logic              ddc1_sda,
    output logic              ddc1_req,
    output logic              ddc2_mode,
    input  logic [6:0]        a_addr,
    input  logic [1:0]        a_width,
    input  logic [6:0]        b_addr,
    input  logic              adr_valid,
    input  logic [7:0]        adr_byte,
    output logic              adr_ack,
    output logic              sel_a,
    output logic              sel_b,
    output logic [1:0]        a_wild,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rx_a_data,
    output logic              rx_a_stb,
    output logic [DATA_W-1:0] rx_b_data,
    output logic              rx_b_stb,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] tx_a_data,
    input  logic [DATA_W-1:0] tx_b_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_stb,
    input  logic              stop
);
    typedef struct packed {
        logic vs_prev;
    } edge_st_t;

    edge_st_t ed_d, ed_q;
    logic     vs_rise;
    logic     two_way;
    logic     shf_sda;

    always_comb begin
        ed_d         = ed_q;
        ed_d.vs_prev = vsync_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ed_q.vs_prev <= 1'b1;
        end else begin
            ed_q <= ed_d;
        end
    end

    assign vs_rise = vsync_in && !ed_q.vs_prev;

    ddc_mode_fsm #(.IDLE_VSYNC(IDLE_VSYNC)) i_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .vs_rise(vs_rise),
        .ddc2_o (two_way)
    );

    ddc1_shifter #(.DATA_W(DATA_W)) i_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!two_way),
        .vs_rise (vs_rise),
        .buf_byte(ddc1_byte),
        .sda_o   (shf_sda),
        .req_o   (ddc1_req)
    );

    ddc2_slave #(.DATA_W(DATA_W)) i_slv (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (two_way),
        .a_addr   (a_addr),
        .a_width  (a_width),
        .b_addr   (b_addr),
        .adr_valid(adr_valid),
        .adr_byte (adr_byte),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .rd_req   (rd_req),
        .stop     (stop),
        .tx_a_data(tx_a_data),
        .tx_b_data(tx_b_data),
        .adr_ack  (adr_ack),
        .sel_a    (sel_a),
        .sel_b    (sel_b),
        .a_wild   (a_wild),
        .rx_a_data(rx_a_data),
        .rx_a_stb (rx_a_stb),
        .rx_b_data(rx_b_data),
        .rx_b_stb (rx_b_stb),
        .rd_data  (rd_data),
        .rd_stb   (rd_stb)
    );

    assign ddc2_mode = two_way;
    assign ddc1_sda  = shf_sda | two_way;
endmodule

// File: rtl/ddc_slave_ctrl_chk.sv
module ddc_slave_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic vsync_in,
    input logic ddc1_req,
    input logic ddc2_mode,
    input logic adr_valid,
    input logic adr_ack,
    input logic sel_a,
    input logic sel_b,
    input logic wr_valid,
    input logic rx_a_stb,
    input logic rx_b_stb,
    input logic rd_req,
    input logic rd_stb
);
    logic scl_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) scl_seen_q <= 1'b1;
        else        scl_seen_q <= scl_in;
    end

    p_req_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ddc1_req |-> ($past(vsync_in) && !$past(vsync_in, 2)));

    p_enter_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ddc2_mode && scl_seen_q && !scl_in) |=> ddc2_mode);

    p_exit_scl_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ddc2_mode) |-> $past(scl_in));

    p_single_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_a, sel_b}));

    p_ack_after_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adr_ack |-> $past(adr_valid));

    p_rx_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_a_stb || rx_b_stb) |-> $past(wr_valid));

    p_rd_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> $past(rd_req));

    p_ack_only_two_way_r11: assert property (@(posedge clk) disable iff (!rst_n)
        adr_ack |-> $past(ddc2_mode));
endmodule

bind ddc_slave_ctrl ddc_slave_ctrl_chk i_chk (.*);

// File: tb/test_ddc_slave_ctrl.sv
module test_ddc_slave_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1;
    logic       vsync_in = 1'b0;
    logic [7:0] ddc1_byte = '0;
    logic       ddc1_sda, ddc1_req, ddc2_mode;
    logic [6:0] a_addr = '0;
    logic [1:0] a_width = '0;
    logic [6:0] b_addr = '0;
    logic       adr_valid = 1'b0;
    logic [7:0] adr_byte = '0;
    logic       adr_ack, sel_a, sel_b;
    logic [1:0] a_wild;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rx_a_data, rx_b_data, rd_data;
    logic       rx_a_stb, rx_b_stb, rd_stb;
    logic       rd_req = 1'b0;
    logic [7:0] tx_a_data = '0;
    logic [7:0] tx_b_data = '0;
    logic       stop = 1'b0;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic got_req;
    logic [1:0] m_wild = '0;

    always #2.5 clk = ~clk;

    ddc_slave_ctrl i_ddc_slave_ctrl (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic vs_pulse();
        vsync_in = 1'b1;
        step();
        got_req = ddc1_req;
        vsync_in = 1'b0;
        step();
    endtask

    task automatic enter_two_way();
        scl_in = 1'b0;
        step();
        scl_in = 1'b1;
        step();
    endtask

    function automatic logic [6:0] care_of(input logic [1:0] code);
        case (code)
            2'd1:    return 7'b1111110;
            2'd2:    return 7'b1111100;
            default: return 7'b1111111;
        endcase
    endfunction

    function automatic bit exp_hit_a(input logic [6:0] own, input logic [1:0] code, input logic [6:0] ad);
        return ((own ^ ad) & care_of(code)) == 7'd0;
    endfunction

    task automatic send_addr(input logic [7:0] b);
        adr_byte = b;
        adr_valid = 1'b1;
        step();
        adr_valid = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            report();
        end
    end

    initial begin
        logic [7:0] byt;
        void'($urandom(32'd1207));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check(ddc2_mode == 1'b0, "R1 mode", ddc2_mode, 0);
        check(ddc1_sda == 1'b1, "R1 sda", ddc1_sda, 1);
        check({ddc1_req, adr_ack, sel_a, sel_b, rx_a_stb, rx_b_stb, rd_stb} == '0, "R1 flags",
              {ddc1_req, adr_ack, sel_a, sel_b, rx_a_stb, rx_b_stb, rd_stb}, 0);

        // R11 address in one-way mode ignored
        a_addr = 7'h50; b_addr = 7'h37; a_width = 2'd0;
        send_addr({7'h50, 1'b0});
        check(adr_ack == 1'b0 && sel_a == 1'b0, "R11 no ack", {adr_ack, sel_a}, 0);
        step();

        // R2 / R3 serial frames
        for (int f = 0; f < 3; f++) begin
            byt = (f == 0) ? 8'hA5 : 8'($urandom);
            ddc1_byte = byt;
            vs_pulse();
            check(got_req == 1'b1, "R3 req at frame start", got_req, 1);
            check(ddc1_sda == byt[7], "R2 bit7", ddc1_sda, byt[7]);
            ddc1_byte = ~byt;
            for (int k = 6; k >= 0; k--) begin
                vs_pulse();
                check(got_req == 1'b0, "R3 no req mid frame", got_req, 0);
                check(ddc1_sda == byt[k], "R2 data bit", ddc1_sda, byt[k]);
            end
            vs_pulse();
            check(ddc1_sda == 1'b1 && got_req == 1'b0, "R2 ninth slot high", {ddc1_sda, got_req}, 2);
        end
        ddc1_byte = 8'h00;
        vs_pulse();
        check(ddc1_sda == 1'b0, "R2 zero byte", ddc1_sda, 0);

        // R4 enter two-way mode on scl fall
        scl_in = 1'b0;
        step();
        check(ddc2_mode == 1'b1, "R4 enter", ddc2_mode, 1);
        check(ddc1_sda == 1'b1, "R4 sda high", ddc1_sda, 1);
        scl_in = 1'b1;
        step();
        vs_pulse();
        check(got_req == 1'b0 && ddc1_sda == 1'b1, "R4 no shifting", {got_req, ddc1_sda}, 1);

        // R5 idle count, with restart by scl low
        for (int i = 0; i < 100; i++) vs_pulse();
        scl_in = 1'b0; step(); scl_in = 1'b1; step();
        for (int i = 0; i < 127; i++) vs_pulse();
        check(ddc2_mode == 1'b1, "R5 count restarted", ddc2_mode, 1);
        vs_pulse();
        check(ddc2_mode == 1'b0, "R5 exit after 128", ddc2_mode, 0);
        enter_two_way();
        for (int i = 0; i < 127; i++) vs_pulse();
        check(ddc2_mode == 1'b1, "R5 still two-way at 127", ddc2_mode, 1);
        vs_pulse();
        check(ddc2_mode == 1'b0, "R5 exit", ddc2_mode, 0);
        enter_two_way();

        // R6/R7/R8 directed: 5-bit A overlaps B, A wins
        a_addr = 7'b1010000; a_width = 2'd2; b_addr = 7'b1010011;
        send_addr({7'b1010011, 1'b0});
        check(adr_ack && sel_a && !sel_b, "R8 A priority", {adr_ack, sel_a, sel_b}, 3'b110);
        check(a_wild == 2'b11, "R7 wild five", a_wild, 3);
        m_wild = 2'b11;
        a_width = 2'd0;
        send_addr({7'b1010011, 1'b1});
        check(!sel_a && sel_b && adr_ack, "R8 B full match", {sel_a, sel_b}, 1);
        check(a_wild == 2'b11, "R7 wild kept", a_wild, 3);

        // R9 write to unselected ignored
        send_addr({7'h7F, 1'b0});
        check(!adr_ack && !sel_a && !sel_b, "R8 no match", {adr_ack, sel_a, sel_b}, 0);
        wr_valid = 1'b1; wr_data = 8'h3C; step(); wr_valid = 1'b0;
        check(!rx_a_stb && !rx_b_stb, "R9 unselected ignored", {rx_a_stb, rx_b_stb}, 0);

        // random address / data traffic
        for (int it = 0; it < 60; it++) begin
            logic [6:0] ad;
            logic       rw, ha, hb;
            a_addr  = 7'($urandom);
            a_width = 2'($urandom);
            b_addr  = ($urandom % 2) ? (a_addr ^ 7'($urandom % 4)) : 7'($urandom);
            ad      = ($urandom % 4 != 0) ? (a_addr ^ 7'($urandom % 4)) : 7'($urandom);
            rw      = 1'($urandom);
            ha = exp_hit_a(a_addr, a_width, ad);
            hb = (ad == b_addr);
            send_addr({ad, rw});
            if (ha) m_wild = ad[1:0] & ~care_of(a_width)[1:0];
            check(adr_ack == (ha | hb), "R8 ack", adr_ack, ha | hb);
            check(sel_a == ha && sel_b == (!ha && hb), "R6 select", {sel_a, sel_b}, {ha, !ha && hb});
            check(a_wild == m_wild, "R7 wild", a_wild, m_wild);
            byt = 8'($urandom);
            if (!rw) begin
                wr_data = byt; wr_valid = 1'b1; step(); wr_valid = 1'b0;
                check(rx_a_stb == ha && rx_b_stb == (!ha && hb), "R9 strobes", {rx_a_stb, rx_b_stb}, {ha, !ha && hb});
                if (ha) check(rx_a_data == byt, "R9 data a", rx_a_data, byt);
                if (!ha && hb) check(rx_b_data == byt, "R9 data b", rx_b_data, byt);
            end else begin
                tx_a_data = byt; tx_b_data = ~byt;
                rd_req = 1'b1; step(); rd_req = 1'b0;
                check(rd_stb == (ha | hb), "R10 rd strobe", rd_stb, ha | hb);
                if (ha | hb) check(rd_data == (ha ? byt : ~byt), "R10 rd data", rd_data, ha ? byt : ~byt);
                wr_valid = 1'b1; step(); wr_valid = 1'b0;
                check(!rx_a_stb && !rx_b_stb, "R9 read ignores write", {rx_a_stb, rx_b_stb}, 0);
            end
            stop = 1'b1; step(); stop = 1'b0;
            check(!sel_a && !sel_b, "R10 stop clears", {sel_a, sel_b}, 0);
            rd_req = 1'b1; step(); rd_req = 1'b0;
            check(!rd_stb, "R10 no read after stop", rd_stb, 0);
        end

        // R6 six-bit mode directed
        a_addr = 7'b0110110; a_width = 2'd1; b_addr = 7'h00;
        send_addr({7'b0110111, 1'b0});
        check(sel_a && a_wild == 2'b01, "R6 six bit wild", {sel_a, a_wild}, 3'b101);
        send_addr({7'b0110100, 1'b0});
        check(!sel_a && !adr_ack, "R6 bit1 compared", {sel_a, adr_ack}, 0);

        done = 1'b1;
        report();
    end
endmodule